// File: doc/BRIEF.md
# Load-Store Queue with Store-to-Load Forwarding

This block keeps the in-flight memory operations of an out-of-order core in program order, from allocation to retirement. Each slot records whether it is a load or a store, a sequence tag, a memory address with a valid bit, and a data value with a valid bit. Slots are handed out at the tail. Store addresses and store data then arrive at any time and in any order, written by slot index.

When a load asks to issue, the queue first checks that every store older than the load already has its address. It then searches all older stores for one with the same address. If matches exist, the load takes the value of the nearest older one. If there is no match, it reads the data cache. If the nearest matching store's value is still missing, the load must retry later.

Retirement frees slots from the head in order. A retiring store writes its address and value to the cache in that same cycle. A retiring load only frees its slot.

Top module: `lsq_fwd`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_idx` is 0, `retire_ready` is 0 and `ld_resp_valid` is 0.
- R2: Slots are handed out in ring order. `alloc_idx` is the next slot number, counting up and wrapping at DEPTH. `alloc_ready` is 0 exactly when DEPTH slots are occupied.
- R3: A load request is refused (`ld_req_ready` is 0) while any older store in the queue has no address yet.
- R4: When older stores to the load's address exist, the response carries the value of the nearest older one, with `ld_resp_fwd` = 1. Stores younger than the load have no effect on its value.
- R5: With no matching older store, an accepted load raises `cache_rd_en` with `cache_rd_addr` equal to the load address. Its response carries the `cache_rd_data` of that cycle, with `ld_resp_fwd` = 0.
- R6: A load whose nearest matching older store has no data yet is refused (`ld_req_ready` = 0).
- R7: An accepted load produces exactly one response on the next cycle, tagged with the sequence number given at allocation.
- R8: The head store may retire only once both its address and its data are present. When it retires, `cache_wr_en` is 1 in that cycle, with the store's address and data.
- R9: The head load may retire only after its response has been produced. Retiring a load never raises `cache_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate a slot at the tail |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_seq | input | SEQ_W | Sequence tag of the new operation |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | $clog2(DEPTH) | Slot that the next allocation takes |
| sa_valid | input | 1 | Write a store address |
| sa_idx | input | $clog2(DEPTH) | Slot of that store |
| sa_addr | input | ADDR_W | Store address |
| sd_valid | input | 1 | Write store data |
| sd_idx | input | $clog2(DEPTH) | Slot of that store |
| sd_data | input | DATA_W | Store value |
| ld_req_valid | input | 1 | Load asks to issue |
| ld_req_idx | input | $clog2(DEPTH) | Slot of the load |
| ld_req_addr | input | ADDR_W | Load address |
| ld_req_ready | output | 1 | Load may issue now |
| ld_resp_valid | output | 1 | Load result valid |
| ld_resp_seq | output | SEQ_W | Sequence tag of the answered load |
| ld_resp_data | output | DATA_W | Load value |
| ld_resp_fwd | output | 1 | Value came from a queued store |
| cache_rd_en | output | 1 | Cache read for the issuing load |
| cache_rd_addr | output | ADDR_W | Cache read address |
| cache_rd_data | input | DATA_W | Cache read value, same cycle |
| retire_valid | input | 1 | Retire the head slot |
| retire_ready | output | 1 | Head slot may retire |
| cache_wr_en | output | 1 | Retiring store writes the cache |
| cache_wr_addr | output | ADDR_W | Cache write address |
| cache_wr_data | output | DATA_W | Cache write value |

## Verification
Random traffic draws addresses from a pool of four words, so loads often hit several older stores to the same address, sometimes miss all of them, and sometimes face stores whose address or data is still missing. A run that only matched one store would not tell nearest-older selection apart from any-older selection. The directed sequence uses two stores (-17, then 0) to one address, each followed by a load. This separates the nearest older store from a younger store, and a forwarded value from a cache value. Filling the ring, then retiring and allocating past the wrap, tests pointer wrap, the full condition, and age ordering across the wrap.

// File: rtl/lsq_pkg.sv
// Package: shared types and helpers for the load-store queue.
// Assumes the queue depth is a power of two, so ages wrap naturally.
package lsq_pkg;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } lsq_op_e;

endpackage

// File: rtl/lsq_ring_ptrs.sv
// Ring pointer control: head, tail and occupancy of the queue.
// Assumes push is never asserted when full and pop never when empty.
module lsq_ring_ptrs #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [IW-1:0] head,
    output logic [IW-1:0] tail,
    output logic [CW-1:0] count
);

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= tail + 1'b1;
            if (pop)  head <= head + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R2
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/lsq_fwd_search.sv
// Forwarding search: starting from the slot just older than the load and
// walking toward the head, finds the first store with a matching address.
// It also flags any older store whose address is still missing.
// Assumes the load slot is valid and occupancy metadata is current.
module lsq_fwd_search #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             valid,
    input  logic [DEPTH-1:0]             is_st,
    input  logic [DEPTH-1:0]             addr_v,
    input  logic [DEPTH-1:0][ADDR_W-1:0] addr,
    input  logic [DEPTH-1:0]             data_v,
    input  logic [DEPTH-1:0][DATA_W-1:0] data,
    input  logic [IW-1:0]                head,
    input  logic [IW-1:0]                ld_idx,
    input  logic [ADDR_W-1:0]            ld_addr,
    output logic                         stall,
    output logic                         hit,
    output logic [DATA_W-1:0]            fwd_data
);

    logic          unknown;
    logic [IW-1:0] hit_idx;
    logic [IW-1:0] ld_age;

    // Priority walk from the youngest older slot toward the head.
    always_comb begin
        ld_age  = ld_idx - head;
        unknown = 1'b0;
        hit     = 1'b0;
        hit_idx = '0;
        for (int k = 1; k < DEPTH; k++) begin
            logic [IW-1:0] i;
            i = ld_idx - IW'(k);
            if ((IW'(k) <= ld_age) && valid[i] && is_st[i]) begin
                if (!addr_v[i]) begin
                    unknown = 1'b1;
                end else if ((addr[i] == ld_addr) && !hit) begin
                    hit     = 1'b1;
                    hit_idx = i;
                end
            end
        end
    end

    // Stall on unknown older address or missing forwarded data.
    always_comb begin
        stall    = unknown || (hit && !data_v[hit_idx]);
        fwd_data = data[hit_idx];
    end

endmodule

// File: rtl/lsq_fwd.sv
// Load-store queue top: slot storage, load issue and response, retirement.
// Assumes: address/data writes target valid store slots; load requests
// target valid, not-yet-answered load slots; retire_valid is only honoured
// when retire_ready is high.
module lsq_fwd
    import lsq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SEQ_W  = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = IW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_store,
    input  logic [SEQ_W-1:0]  alloc_seq,
    output logic              alloc_ready,
    output logic [IW-1:0]     alloc_idx,
    input  logic              sa_valid,
    input  logic [IW-1:0]     sa_idx,
    input  logic [ADDR_W-1:0] sa_addr,
    input  logic              sd_valid,
    input  logic [IW-1:0]     sd_idx,
    input  logic [DATA_W-1:0] sd_data,
    input  logic              ld_req_valid,
    input  logic [IW-1:0]     ld_req_idx,
    input  logic [ADDR_W-1:0] ld_req_addr,
    output logic              ld_req_ready,
    output logic              ld_resp_valid,
    output logic [SEQ_W-1:0]  ld_resp_seq,
    output logic [DATA_W-1:0] ld_resp_data,
    output logic              ld_resp_fwd,
    output logic              cache_rd_en,
    output logic [ADDR_W-1:0] cache_rd_addr,
    input  logic [DATA_W-1:0] cache_rd_data,
    input  logic              retire_valid,
    output logic              retire_ready,
    output logic              cache_wr_en,
    output logic [ADDR_W-1:0] cache_wr_addr,
    output logic [DATA_W-1:0] cache_wr_data
);

    logic [DEPTH-1:0]             valid_q;
    logic [DEPTH-1:0]             st_q;
    logic [DEPTH-1:0][SEQ_W-1:0]  seq_q;
    logic [DEPTH-1:0]             av_q;
    logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
    logic [DEPTH-1:0]             dv_q;
    logic [DEPTH-1:0][DATA_W-1:0] data_q;

    logic [IW-1:0]     head, tail;
    logic [CW-1:0]     count;
    logic              al_fire, rt_fire, ld_fire;
    logic              srch_stall, srch_hit;
    logic [DATA_W-1:0] srch_data, ld_value;

    lsq_ring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (al_fire),
        .pop   (rt_fire),
        .head  (head),
        .tail  (tail),
        .count (count)
    );

    lsq_fwd_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_search (
        .valid    (valid_q),
        .is_st    (st_q),
        .addr_v   (av_q),
        .addr     (addr_q),
        .data_v   (dv_q),
        .data     (data_q),
        .head     (head),
        .ld_idx   (ld_req_idx),
        .ld_addr  (ld_req_addr),
        .stall    (srch_stall),
        .hit      (srch_hit),
        .fwd_data (srch_data)
    );

    // Handshakes, cache read and head retirement conditions.
    always_comb begin
        alloc_ready   = (count != CW'(DEPTH));
        alloc_idx     = tail;
        al_fire       = alloc_valid && alloc_ready;
        ld_req_ready  = !srch_stall;
        ld_fire       = ld_req_valid && ld_req_ready;
        cache_rd_en   = ld_fire && !srch_hit;
        cache_rd_addr = ld_req_addr;
        ld_value      = srch_hit ? srch_data : cache_rd_data;
        retire_ready  = valid_q[head] && dv_q[head] &&
                        (st_q[head] != OP_STORE || av_q[head]);
        rt_fire       = retire_valid && retire_ready;
        cache_wr_en   = rt_fire && (st_q[head] == OP_STORE);
        cache_wr_addr = addr_q[head];
        cache_wr_data = data_q[head];
    end

    // Slot storage updates: allocate, store writes, load result, retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            st_q    <= '0;
            av_q    <= '0;
            dv_q    <= '0;
            seq_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            if (rt_fire) valid_q[head] <= 1'b0;
            if (al_fire) begin
                valid_q[tail] <= 1'b1;
                st_q[tail]    <= alloc_store;
                seq_q[tail]   <= alloc_seq;
                av_q[tail]    <= 1'b0;
                dv_q[tail]    <= 1'b0;
            end
            if (sa_valid) begin
                av_q[sa_idx]   <= 1'b1;
                addr_q[sa_idx] <= sa_addr;
            end
            if (sd_valid) begin
                dv_q[sd_idx]   <= 1'b1;
                data_q[sd_idx] <= sd_data;
            end
            if (ld_fire) begin
                av_q[ld_req_idx]   <= 1'b1;
                addr_q[ld_req_idx] <= ld_req_addr;
                dv_q[ld_req_idx]   <= 1'b1;
                data_q[ld_req_idx] <= ld_value;
            end
        end
    end

    // Registered load response, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_resp_valid <= 1'b0;
            ld_resp_seq   <= '0;
            ld_resp_data  <= '0;
            ld_resp_fwd   <= 1'b0;
        end else begin
            ld_resp_valid <= ld_fire;
            ld_resp_seq   <= seq_q[ld_req_idx];
            ld_resp_data  <= ld_value;
            ld_resp_fwd   <= srch_hit;
        end
    end

    // R7
    resp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_resp_valid |-> $past(ld_req_valid && ld_req_ready));

    // R5
    rd_not_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_rd_en |-> (ld_req_valid && ld_req_ready));

    // R2
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_ready |-> (valid_q == {DEPTH{1'b1}}));

    // R8
    wr_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_wr_en |-> (av_q[head] && dv_q[head] && valid_q[head]));

endmodule

// File: tb/sim_lsq_fwd.sv
// Bench: directed forwarding cases plus seeded random traffic, checked
// against a slot-level model kept in the bench.
module sim_lsq_fwd;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid, alloc_store;
    logic [7:0]  alloc_seq;
    logic        alloc_ready;
    logic [2:0]  alloc_idx;
    logic        sa_valid, sd_valid, ld_req_valid, retire_valid;
    logic [2:0]  sa_idx, sd_idx, ld_req_idx;
    logic [15:0] sa_addr, sd_data, ld_req_addr;
    logic        ld_req_ready, ld_resp_valid, ld_resp_fwd;
    logic [7:0]  ld_resp_seq;
    logic [15:0] ld_resp_data;
    logic        cache_rd_en, retire_ready, cache_wr_en;
    logic [15:0] cache_rd_addr, cache_rd_data, cache_wr_addr, cache_wr_data;

    logic [15:0] cmem [4];
    assign cache_rd_data = cmem[cache_rd_addr[1:0]];

    int errors = 0, checks = 0, cyc = 0;

    bit          m_v [D], m_st [D], m_av [D], m_dv [D];
    logic [15:0] m_a [D], m_d [D];
    logic [7:0]  m_sq [D];
    int          m_head = 0, m_tail = 0, m_cnt = 0;
    logic [7:0]  next_seq = 8'd1;

    lsq_fwd u0 (.*);

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int age(input int i);
        return (i - m_head + D) % D;
    endfunction

    task automatic idle_inputs();
        alloc_valid = 0; alloc_store = 0; alloc_seq = 0;
        sa_valid = 0; sa_idx = 0; sa_addr = 0;
        sd_valid = 0; sd_idx = 0; sd_data = 0;
        ld_req_valid = 0; ld_req_idx = 0; ld_req_addr = 0;
        retire_valid = 0;
    endtask

    task automatic do_alloc(input bit st, output int slot);
        @(negedge clk);
        alloc_valid = 1; alloc_store = st; alloc_seq = next_seq;
        #1;
        chk(alloc_ready == (m_cnt < D), "R2 ready", alloc_ready, m_cnt < D);
        chk(alloc_idx == 3'(m_tail), "R2 idx", alloc_idx, m_tail);
        slot = m_tail;
        @(posedge clk);
        if (m_cnt < D) begin
            m_v[m_tail] = 1; m_st[m_tail] = st; m_av[m_tail] = 0; m_dv[m_tail] = 0;
            m_sq[m_tail] = next_seq; next_seq++;
            m_tail = (m_tail + 1) % D; m_cnt++;
        end else slot = -1;
        #1 alloc_valid = 0;
    endtask

    task automatic do_saddr(input int i, input logic [15:0] a);
        @(negedge clk);
        sa_valid = 1; sa_idx = 3'(i); sa_addr = a;
        @(posedge clk);
        m_av[i] = 1; m_a[i] = a;
        #1 sa_valid = 0;
    endtask

    task automatic do_sdata(input int i, input logic [15:0] d);
        @(negedge clk);
        sd_valid = 1; sd_idx = 3'(i); sd_data = d;
        @(posedge clk);
        m_dv[i] = 1; m_d[i] = d;
        #1 sd_valid = 0;
    endtask

    task automatic do_load(input int li, input logic [15:0] la);
        bit blk = 0, wt = 0, hit = 0;
        int best = -1;
        logic [15:0] exp_d;
        for (int i = 0; i < D; i++)
            if (m_v[i] && m_st[i] && age(i) < age(li)) begin
                if (!m_av[i]) blk = 1;
                else if (m_a[i] == la && (best < 0 || age(i) > age(best))) best = i;
            end
        hit = (best >= 0);
        if (hit) wt = !m_dv[best];
        exp_d = hit ? m_d[best] : cmem[la[1:0]];
        @(negedge clk);
        ld_req_valid = 1; ld_req_idx = 3'(li); ld_req_addr = la;
        #1;
        if (blk) chk(ld_req_ready == 0, "R3 unknown older addr", ld_req_ready, 0);
        else if (wt) chk(ld_req_ready == 0, "R6 data wait", ld_req_ready, 0);
        else begin
            chk(ld_req_ready == 1, "R4/R5 ready", ld_req_ready, 1);
            chk(cache_rd_en == !hit, "R5 rd_en", cache_rd_en, !hit);
            if (!hit) chk(cache_rd_addr == la, "R5 rd_addr", cache_rd_addr, la);
        end
        @(posedge clk);
        #1;
        ld_req_valid = 0;
        if (!blk && !wt) begin
            chk(ld_resp_valid == 1, "R7 resp valid", ld_resp_valid, 1);
            chk(ld_resp_seq == m_sq[li], "R7 seq", ld_resp_seq, m_sq[li]);
            chk(ld_resp_data == exp_d, hit ? "R4 fwd data" : "R5 cache data", ld_resp_data, exp_d);
            chk(ld_resp_fwd == hit, "R4 fwd flag", ld_resp_fwd, hit);
            m_av[li] = 1; m_a[li] = la; m_dv[li] = 1; m_d[li] = exp_d;
        end else
            chk(ld_resp_valid == 0, "R7 no resp", ld_resp_valid, 0);
    endtask

    task automatic do_retire();
        bit rdy;
        int h = m_head;
        rdy = m_v[h] && m_dv[h] && (!m_st[h] || m_av[h]);
        @(negedge clk);
        retire_valid = 1;
        #1;
        chk(retire_ready == rdy, m_st[h] ? "R8 ready" : "R9 ready", retire_ready, rdy);
        if (rdy && m_st[h]) begin
            chk(cache_wr_en == 1, "R8 wr_en", cache_wr_en, 1);
            chk(cache_wr_addr == m_a[h], "R8 wr_addr", cache_wr_addr, m_a[h]);
            chk(cache_wr_data == m_d[h], "R8 wr_data", cache_wr_data, m_d[h]);
        end else
            chk(cache_wr_en == 0, "R9 no write", cache_wr_en, 0);
        @(posedge clk);
        if (rdy) begin
            if (m_st[h]) cmem[m_a[h][1:0]] = m_d[h];
            m_v[h] = 0; m_head = (m_head + 1) % D; m_cnt--;
        end
        #1 retire_valid = 0;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : main
        int s0, l0, s1, l1, sl, tmp;
        void'($urandom(32'h5eed_1a2b));
        for (int k = 0; k < 4; k++) cmem[k] = 16'h1000 + 16'(k);
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(alloc_ready == 1, "R1 alloc_ready", alloc_ready, 1);
        chk(alloc_idx == 0, "R1 alloc_idx", alloc_idx, 0);
        chk(retire_ready == 0, "R1 retire_ready", retire_ready, 0);
        chk(ld_resp_valid == 0, "R1 resp", ld_resp_valid, 0);

        // Directed: two stores to one address, each followed by a load (R4)
        do_alloc(1, s0); do_alloc(0, l0); do_alloc(1, s1); do_alloc(0, l1);
        do_load(l0, 16'h3290);            // R3: s0 address unknown
        do_saddr(s0, 16'h3290);
        do_load(l0, 16'h3290);            // R6: s0 data missing
        do_sdata(s0, 16'hFFEF);
        do_sdata(s1, 16'h0000);
        do_load(l1, 16'h3290);            // R3: s1 address unknown
        do_saddr(s1, 16'h3290);
        do_load(l1, 16'h3290);            // R4: nearest older gives 0
        do_load(l0, 16'h3290);            // R4: younger s1 ignored, gives -17
        do_alloc(0, sl);
        do_load(sl, 16'h3291);            // R5: miss goes to cache
        repeat (5) do_retire();           // R8, R9
        do_retire();                      // R9: empty queue, not ready

        // Fill ring to check full (R2)
        for (int k = 0; k < D; k++) do_alloc(0, tmp);
        do_alloc(0, tmp);
        for (int k = 0; k < D; k++) begin
            do_load(m_head, 16'h3290 + 16'(k % 4));
            do_retire();
        end

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            int pick = $urandom_range(0, 5);
            int i = $urandom_range(0, D - 1);
            logic [15:0] a = 16'h3290 + 16'($urandom_range(0, 3));
            case (pick)
                0: if (m_cnt < D) do_alloc($urandom_range(0, 1), tmp);
                1: if (m_v[i] && m_st[i] && !m_av[i]) do_saddr(i, a);
                2: if (m_v[i] && m_st[i] && !m_dv[i]) do_sdata(i, 16'($urandom));
                3: if (m_v[i] && !m_st[i] && !m_dv[i]) do_load(i, a);
                4: if (m_cnt > 0) do_retire();
                default: if (m_cnt < D) do_alloc(1, tmp);
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule